// File: doc/BRIEF.md
# Watchdog Timer with Reset Output

This block is a register-mapped watchdog. Software picks a timeout as a whole number of half-second periods, chooses what an expiry does, and then starts the countdown. A free-running tick input, pulsing once every 0.5 s, drives the countdown. Software must write a restart command before the count runs out. If the count reaches its end, the expiry can set a pending interrupt, start a fixed-length reset request toward the system reset sequencer, do both, or do neither. Each of these routes has its own configuration bit, and the interrupt mask lives in a separate register.

Every expiry sets a sticky status flag, whatever routing is selected. The countdown then reloads itself and keeps running, so a timer that is never serviced expires once per interval. The register bus is a plain 32-bit interface with address, write strobe, write data and combinational read data. The asynchronous active-low reset is released synchronously inside the block.

Top module: `wdog_top`

## Requirements
- R1: After reset, irq and rst_req are low and every register reads back as zero.
- R2: Register map, with unmapped offsets and the control register reading zero:
  - 0x00: bit 0 is the interrupt mask, bit 1 is the pending flag (write 1 to clear) and bit 2 is the sticky expiry flag (write 1 to clear).
  - 0x10: control, where a 1 written to bit 0 restarts the count.
  - 0x14: routing, where bit 0 sends an expiry to reset and bit 1 sends it to the interrupt.
  - 0x18: mode, where bit 0 is the run enable and bits starting at bit 4 hold an IVL_W-bit interval field. These read back as written.
- R3: Writing the mode register with bit 0 set while the timer is stopped loads N ticks, where N is the interval field, or 1 when the field is 0. The expiry happens on the N-th tick after that write, and its effects are visible in the cycle after that tick is sampled.
- R4: Writing 1 to control bit 0 reloads N ticks. A control write with bit 0 clear has no effect on the count.
- R5: Rewriting the mode register with bit 0 set while the timer already runs neither reloads nor stops the count.
- R6: Clearing mode bit 0 stops the count, and ticks are then ignored. Enabling again reloads N.
- R7: An expiry with routing bit 1 set raises the pending flag, and irq is the pending flag ANDed with the mask. Writing 1 to bit 1 of offset 0x00 clears pending. If an expiry and that clear arrive in the same cycle, the expiry wins.
- R8: An expiry with routing bit 0 set drives rst_req high for exactly RST_CYCLES clock cycles. An expiry during an active pulse does not extend it.
- R9: Every expiry sets the sticky flag, whatever the routing bits are. It stays set until 1 is written to bit 2 of offset 0x00.
- R10: On expiry the count reloads N and continues, so an unserviced timer expires every N ticks.
- R11: A restart write in the same cycle as a tick wins: there is no expiry, and the full N ticks are reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 0.5 s |
| addr | input | 8 | Register byte offset |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level interrupt, pending AND mask |
| rst_req | output | 1 | Reset request pulse to the sequencer |

## Verification
The bench builds the block with IVL_W = 3 and RST_CYCLES = 5. With these values the interval field has only eight values, so every interval from the default up to 7 ticks can be swept against all four routing combinations. Each sweep point checks the exact tick of expiry and the exact reset pulse width. The short pulse also keeps the width measurement cheap, and directed sequences then cover restart, enable rewrite, stop, masking, periodic expiry and the restart-versus-tick collision.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_IRQ  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h18;

  // bit positions inside the interrupt register
  localparam int IRQ_MASK_BIT = 0;
  localparam int IRQ_PEND_BIT = 1;
  localparam int IRQ_STAT_BIT = 2;

  // routing register
  localparam int CFG_RST_BIT = 0;
  localparam int CFG_IRQ_BIT = 1;

  // mode register
  localparam int MODE_RUN_BIT = 0;
  localparam int MODE_IVL_LSB = 4;

  localparam int CTL_KICK_BIT = 0;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int IVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              route_rst,
  output logic              load,
  output logic [IVL_W-1:0]  reload_val,
  output logic              irq
);
  localparam logic [IVL_W-1:0] IVL_DEF = IVL_W'(1);

  logic             mask_q, mask_d;
  logic             pend_q, pend_d;
  logic             stat_q, stat_d;
  logic             crst_q, crst_d;
  logic             cirq_q, cirq_d;
  logic             run_q, run_d;
  logic [IVL_W-1:0] ivl_q, ivl_d;

  logic             wr_irq, wr_ctl, wr_cfg, wr_mode;
  logic [IVL_W-1:0] ivl_eff;

  always_comb begin
    wr_irq  = we && (addr == OFS_IRQ);
    wr_ctl  = we && (addr == OFS_CTL);
    wr_cfg  = we && (addr == OFS_CFG);
    wr_mode = we && (addr == OFS_MODE);

    mask_d = wr_irq ? wdata[IRQ_MASK_BIT] : mask_q;

    if (expire && cirq_q)                 pend_d = 1'b1;
    else if (wr_irq && wdata[IRQ_PEND_BIT]) pend_d = 1'b0;
    else                                  pend_d = pend_q;

    if (expire)                           stat_d = 1'b1;
    else if (wr_irq && wdata[IRQ_STAT_BIT]) stat_d = 1'b0;
    else                                  stat_d = stat_q;

    crst_d = wr_cfg ? wdata[CFG_RST_BIT] : crst_q;
    cirq_d = wr_cfg ? wdata[CFG_IRQ_BIT] : cirq_q;

    run_d  = wr_mode ? wdata[MODE_RUN_BIT] : run_q;
    ivl_d  = wr_mode ? wdata[MODE_IVL_LSB +: IVL_W] : ivl_q;

    ivl_eff    = ivl_d;
    reload_val = (ivl_eff == '0) ? IVL_DEF : ivl_eff;

    // start only on a stopped-to-running transition, or on a restart command
    load = (wr_mode && wdata[MODE_RUN_BIT] && !run_q) ||
           (wr_ctl && wdata[CTL_KICK_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      pend_q <= 1'b0;
      stat_q <= 1'b0;
      crst_q <= 1'b0;
      cirq_q <= 1'b0;
      run_q  <= 1'b0;
      ivl_q  <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      stat_q <= stat_d;
      crst_q <= crst_d;
      cirq_q <= cirq_d;
      run_q  <= run_d;
      ivl_q  <= ivl_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_IRQ: begin
        rdata[IRQ_MASK_BIT] = mask_q;
        rdata[IRQ_PEND_BIT] = pend_q;
        rdata[IRQ_STAT_BIT] = stat_q;
      end
      OFS_CFG: begin
        rdata[CFG_RST_BIT] = crst_q;
        rdata[CFG_IRQ_BIT] = cirq_q;
      end
      OFS_MODE: begin
        rdata[MODE_RUN_BIT]             = run_q;
        rdata[MODE_IVL_LSB +: IVL_W]    = ivl_q;
      end
      default: rdata = '0;
    endcase
  end

  assign run       = run_q;
  assign route_rst = crst_q;
  assign irq       = pend_q & mask_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int IVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [IVL_W-1:0] reload_val,
  output logic             expire
);
  localparam logic [IVL_W-1:0] LAST = IVL_W'(1);

  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step   = run && tick && !load;
    expire = step && (cnt_q == LAST);
    if (load)        cnt_d = reload_val;
    else if (expire) cnt_d = reload_val;
    else if (step)   cnt_d = cnt_q - LAST;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_req
);
  localparam int            CW   = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LEN  = CW'(RST_CYCLES);
  localparam logic [CW-1:0] STEP = CW'(1);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    if (left_q != '0)  left_d = left_q - STEP;
    else if (fire)     left_d = LEN;
    else               left_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign rst_req = (left_q != '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int IVL_W       = 4,
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  logic             rst_int_n;
  logic             run_w, route_rst_w, load_w, expire_w, fire_w;
  logic [IVL_W-1:0] reload_w;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rst_int_n = rst_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq, sd;
      always_comb sd = (sq << 1) | SYNC_STAGES'(1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '0;
        else        sq <= sd;
      end
      assign rst_int_n = sq[SYNC_STAGES-1];
    end
  endgenerate

  wdog_regs #(.IVL_W(IVL_W)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .addr(addr), .we(we), .wdata(wdata),
    .expire(expire_w), .rdata(rdata), .run(run_w), .route_rst(route_rst_w),
    .load(load_w), .reload_val(reload_w), .irq(irq)
  );

  wdog_count #(.IVL_W(IVL_W)) count_i (
    .clk(clk), .rst_n(rst_int_n), .run(run_w), .tick(tick), .load(load_w),
    .reload_val(reload_w), .expire(expire_w)
  );

  assign fire_w = expire_w & route_rst_w;

  wdog_rstgen #(.RST_CYCLES(RST_CYCLES)) rstgen_i (
    .clk(clk), .rst_n(rst_int_n), .fire(fire_w), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              run,
  input logic              expire,
  input logic              fire,
  input logic              rst_req,
  input logic              irq
);
  localparam int RW = $clog2(RST_CYCLES + 2) + 1;

  logic [RW-1:0] run_len_q, run_len_d;

  always_comb run_len_d = rst_req ? run_len_q + RW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len_q <= '0;
    else        run_len_q <= run_len_d;
  end

  assert_rst_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (run_len_q < RW'(RST_CYCLES)));

  assert_rst_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (run_len_q == RW'(RST_CYCLES)));

  assert_rst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rst_req) |=> rst_req);

  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire);

  assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_CTL && wdata[CTL_KICK_BIT]) |-> !expire);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_IRQ && wdata[IRQ_PEND_BIT] && !expire) |=> !irq);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $past(we && addr == OFS_IRQ)));
endmodule

bind wdog_top wdog_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .we(we), .addr(addr), .wdata(wdata),
  .run(run_w), .expire(expire_w), .fire(fire_w), .rst_req(rst_req), .irq(irq)
);

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;
  localparam int IVL_W = 3;
  localparam int RSTC  = 5;

  logic        clk, rst_n, tick, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  wdog_top #(.IVL_W(IVL_W), .RST_CYCLES(RSTC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic kick_with_tick();
    @(negedge clk); addr = 8'h10; wdata = 32'h1; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0; wdata = '0;
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (rst_req && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int w;
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd(8'h00, v); chk("R1 irq reg", v, 32'h0);
    rd(8'h14, v); chk("R1 cfg reg", v, 32'h0);
    rd(8'h18, v); chk("R1 mode reg", v, 32'h0);

    // R2 map readback
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R2 cfg readback", v, 32'h3);
    wr(8'h18, 32'h0000_0050); rd(8'h18, v); chk("R2 mode readback", v, 32'h50);
    wr(8'h10, 32'h1);         rd(8'h10, v); chk("R2 ctl reads zero", v, 32'h0);
    rd(8'h08, v); chk("R2 unmapped zero", v, 32'h0);
    wr(8'h00, 32'h1);         rd(8'h00, v); chk("R2 mask readback", v, 32'h1);
    wr(8'h18, 32'h0);

    // R3 R8 R9 sweep over every interval and routing
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int f = 0; f < 8; f++) begin
        int n;
        n = (f == 0) ? 1 : f;
        wr(8'h14, cfg);
        wr(8'h00, 32'h7);
        wr(8'h18, (f << 4) | 1);
        for (int t = 1; t < n; t++) begin
          do_tick();
          chk("R3 no early irq", {31'b0, irq}, 32'h0);
          chk("R3 no early rst", {31'b0, rst_req}, 32'h0);
        end
        do_tick();
        chk("R3 R7 irq at expiry", {31'b0, irq}, {31'b0, cfg[1]});
        chk("R3 R8 rst at expiry", {31'b0, rst_req}, {31'b0, cfg[0]});
        if (cfg[0]) begin
          pulse_width(w);
          chk("R8 pulse width", w, RSTC);
        end
        rd(8'h00, v);
        chk("R9 sticky and R7 pending", v, {29'b0, 1'b1, cfg[1], 1'b1});
        wr(8'h18, 32'h0);
        wr(8'h00, 32'h6);
        rd(8'h00, v); chk("R9 R7 W1C clear", v, 32'h0);
      end
    end

    // R4 restart reloads
    wr(8'h14, 32'h2); wr(8'h00, 32'h1);
    wr(8'h18, 32'h41);
    repeat (3) do_tick();
    wr(8'h10, 32'h1);
    repeat (3) do_tick();
    chk("R4 restart delays expiry", {31'b0, irq}, 32'h0);
    do_tick();
    chk("R4 expiry after reload", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);
    wr(8'h18, 32'h21);
    do_tick();
    wr(8'h10, 32'h2);
    do_tick();
    chk("R4 ctl bit0 clear no reload", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);

    // R5 rewrite of enable while running
    wr(8'h18, 32'h31);
    repeat (2) do_tick();
    wr(8'h18, 32'h31);
    do_tick();
    chk("R5 rewrite keeps count", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);

    // R6 stop and resume
    wr(8'h18, 32'h21);
    do_tick();
    wr(8'h18, 32'h20);
    repeat (5) do_tick();
    chk("R6 stopped ignores ticks", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R6 no expiry while stopped", v, 32'h1);
    wr(8'h18, 32'h21);
    do_tick();
    chk("R6 re-enable reloads", {31'b0, irq}, 32'h0);
    do_tick();
    chk("R6 expiry after re-enable", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);

    // R7 mask
    wr(8'h00, 32'h0);
    wr(8'h18, 32'h11);
    do_tick();
    chk("R7 masked irq low", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R7 pending while masked", v, 32'h6);
    wr(8'h00, 32'h1);
    chk("R7 unmask raises irq", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h3);
    chk("R7 W1C drops irq", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);

    // R10 periodic expiry
    wr(8'h18, 32'h21);
    repeat (2) do_tick();
    chk("R10 first expiry", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h3);
    do_tick();
    chk("R10 between expiries", {31'b0, irq}, 32'h0);
    do_tick();
    chk("R10 second expiry", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);

    // R11 restart collides with tick
    wr(8'h18, 32'h11);
    kick_with_tick();
    chk("R11 restart beats tick", {31'b0, irq}, 32'h0);
    do_tick();
    chk("R11 expiry on next tick", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h0); wr(8'h00, 32'h7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule